// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block sits behind the host's FIFO register address of a bus-adapter controller. Every host write to that address does one of two things. When the controller is gathering command bytes, the byte is appended to a 32-entry command buffer. Otherwise the byte is pushed into a 16-entry data queue that keeps its own read pointer, write pointer and byte count. Host reads pop the data queue one byte at a time and request an interrupt for each byte they take.

Two commands from the neighbouring command logic also act on the queue. The status-response command preloads the queue with a status byte followed by a zero message byte. The command-take operation hands the queued bytes over as a command. It exposes the byte count and the logical-unit field found in the third entry, patches that field into entry 0, and empties the queue.

A peek port lets the command logic read any queue entry without disturbing the queue. A second read port gives it the captured command bytes. Command interpretation and DMA are handled elsewhere.

Top module: `pio_fifo_cmd`

## Requirements
- R1: After reset, fifo_count, rd_data, overrun, cmd_len, take_len, take_lun, irq_pulse and resp_done are all 0.
- R2: A write while capture_mode is 1 stores wr_data at command index cmd_len and increments cmd_len, which saturates at 32 (further bytes are dropped). The data queue is not changed.
- R3: A write while capture_mode is 0 stores wr_data at the write pointer and increments fifo_count, unless fifo_count is 15. In that case the byte is dropped and overrun becomes 1 and stays 1 until reset.
- R4: A read with fifo_count > 0 and phase_bits != 0 sets rd_data, one cycle later, to the oldest queued byte (first-in first-out). fifo_count decrements and irq_pulse is 1 for exactly that cycle.
- R5: A read with fifo_count > 0 and phase_bits == 3'b000 sets rd_data to 0, decrements fifo_count without advancing the read position, and pulses irq_pulse.
- R6: A read with fifo_count == 0 leaves rd_data and fifo_count unchanged and does not pulse irq_pulse.
- R7: When a read brings fifo_count to 0, both pointers return to entry 0, so the next data write lands at peek index 0.
- R8: resp_load puts resp_status at entry 0 and 0x00 at entry 1, sets fifo_count to 2 with both pointers at 0, and pulses irq_pulse and resp_done one cycle later.
- R9: cmd_take sets take_len to the fifo_count before the take and take_lun to entry 2 bits [7:5]. Entry 0 becomes {5'b0, take_lun}, and fifo_count and both pointers become 0.
- R10: When several operations are requested in one cycle, only the highest one acts. The order, highest first, is resp_load, cmd_take, read, write.
- R11: cmd_clear sets cmd_len to 0 and takes precedence over a capture write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_mode | input | 1 | 1: host writes go to the command buffer |
| wr_en | input | 1 | Host write strobe to the FIFO address |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe from the FIFO address |
| phase_bits | input | 3 | Bus phase field of the status register |
| rd_data | output | 8 | Registered FIFO read value |
| irq_pulse | output | 1 | One-cycle interrupt request |
| resp_load | input | 1 | Status-response command strobe |
| resp_status | input | 8 | Status byte for the response |
| resp_done | output | 1 | One-cycle pulse after a response is loaded |
| cmd_take | input | 1 | Take queued bytes as a command |
| take_len | output | 5 | Byte count captured by the last take |
| take_lun | output | 3 | Logical-unit field captured by the last take |
| peek_idx | input | 4 | Queue entry to observe |
| peek_data | output | 8 | Queue entry at peek_idx |
| cmd_clear | input | 1 | Empty the command buffer |
| cmd_idx | input | 5 | Command buffer entry to observe |
| cmd_byte | output | 8 | Command buffer entry at cmd_idx |
| cmd_len | output | 6 | Number of captured command bytes |
| fifo_count | output | 5 | Bytes held in the data queue |
| overrun | output | 1 | Sticky queue overrun flag |

## Verification
The hardest state to reach is a read pointer that wraps while the queue is nearly full. Reaching it needs fifteen writes, one partial drain and further writes. Even then, any read that empties the queue snaps both pointers back to entry 0 and erases the wrap. The directed part of the stimulus fills to the overrun limit, reads a few bytes and refills, so the write pointer passes entry 15. The random part biases writes over reads so that long runs stay close to the limit. The same bench also mixes zero phase fields, response loads and takes at arbitrary fill levels into those runs.

// File: rtl/pio_fifo_pkg.sv
package pio_fifo_pkg;
    // Single action granted per cycle, in priority order.
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_RESP,
        ACT_TAKE,
        ACT_READ,
        ACT_PUSH,
        ACT_CAPT
    } act_e;
endpackage

// File: rtl/pio_action_arb.sv
module pio_action_arb
    import pio_fifo_pkg::*;
(
    input  logic resp_load,
    input  logic cmd_take,
    input  logic rd_en,
    input  logic wr_en,
    input  logic capture_mode,
    output act_e act
);
    always_comb begin
        act = ACT_IDLE;
        if (resp_load)         act = ACT_RESP;
        else if (cmd_take)     act = ACT_TAKE;
        else if (rd_en)        act = ACT_READ;
        else if (wr_en)        act = capture_mode ? ACT_CAPT : ACT_PUSH;
    end
endmodule

// File: rtl/pio_byte_store.sv
module pio_byte_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int LUN_IX = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we0,
    input  logic [AW-1:0]     wa0,
    input  logic [DATA_W-1:0] wd0,
    input  logic              we1,
    input  logic [AW-1:0]     wa1,
    input  logic [DATA_W-1:0] wd1,
    input  logic [AW-1:0]     ra,
    output logic [DATA_W-1:0] rdat,
    input  logic [AW-1:0]     pa,
    output logic [DATA_W-1:0] pdat,
    output logic [DATA_W-1:0] lun_src
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we0) mem_d[wa0] = wd0;
        if (we1) mem_d[wa1] = wd1;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdat    = mem_q[ra];
    assign pdat    = mem_q[pa];
    assign lun_src = mem_q[LUN_IX];
endmodule

// File: rtl/pio_cmd_capture.sv
module pio_cmd_capture #(
    parameter int DATA_W    = 8,
    parameter int CMD_DEPTH = 32,
    localparam int CIW      = $clog2(CMD_DEPTH),
    localparam int CLW      = $clog2(CMD_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capt_en,
    input  logic              clear,
    input  logic [DATA_W-1:0] data,
    input  logic [CIW-1:0]    idx,
    output logic [DATA_W-1:0] byte_out,
    output logic [CLW-1:0]    len_q
);
    localparam logic [CLW-1:0] LEN_MAX = CLW'(CMD_DEPTH);

    logic [DATA_W-1:0] buf_q [CMD_DEPTH];
    logic [DATA_W-1:0] buf_d [CMD_DEPTH];
    logic [CLW-1:0]    len_d;

    always_comb begin
        for (int i = 0; i < CMD_DEPTH; i++) buf_d[i] = buf_q[i];
        len_d = len_q;
        if (clear) begin
            len_d = '0;
        end else if (capt_en && (len_q < LEN_MAX)) begin
            buf_d[len_q[CIW-1:0]] = data;
            len_d = len_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            for (int i = 0; i < CMD_DEPTH; i++) buf_q[i] <= '0;
        end else begin
            len_q <= len_d;
            for (int i = 0; i < CMD_DEPTH; i++) buf_q[i] <= buf_d[i];
        end
    end

    assign byte_out = buf_q[idx];
endmodule

// File: rtl/pio_data_ctrl.sv
module pio_data_ctrl
    import pio_fifo_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int PH_W      = 3,
    parameter int LUN_SHIFT = 5,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int LUN_W    = DATA_W - LUN_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PH_W-1:0]   phase_bits,
    input  logic [DATA_W-1:0] resp_status,
    input  logic [DATA_W-1:0] store_rdat,
    input  logic [DATA_W-1:0] lun_src,
    output logic              we0,
    output logic [AW-1:0]     wa0,
    output logic [DATA_W-1:0] wd0,
    output logic              we1,
    output logic [AW-1:0]     wa1,
    output logic [DATA_W-1:0] wd1,
    output logic [AW-1:0]     ra,
    output logic [CW-1:0]     count_q,
    output logic [DATA_W-1:0] rd_data_q,
    output logic              irq_q,
    output logic              done_q,
    output logic              ovr_q,
    output logic [CW-1:0]     tlen_q,
    output logic [LUN_W-1:0]  tlun_q
);
    localparam logic [CW-1:0] CNT_LIMIT = CW'(DEPTH - 1);
    localparam logic [AW-1:0] PTR_LAST  = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0]     rptr;
        logic [AW-1:0]     wptr;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] rdat;
        logic              irq;
        logic              done;
        logic              ovr;
        logic [CW-1:0]     tlen;
        logic [LUN_W-1:0]  tlun;
    } st_t;

    st_t s_q, s_d;
    logic [LUN_W-1:0] lun_fld;
    logic [CW-1:0]    cnt_dec;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign lun_fld = lun_src[DATA_W-1:LUN_SHIFT];
    assign cnt_dec = s_q.cnt - 1'b1;

    always_comb begin
        s_d      = s_q;
        s_d.irq  = 1'b0;
        s_d.done = 1'b0;
        we0 = 1'b0; wa0 = '0; wd0 = '0;
        we1 = 1'b0; wa1 = '0; wd1 = '0;
        unique case (act)
            ACT_RESP: begin
                we0 = 1'b1; wa0 = '0;           wd0 = resp_status;
                we1 = 1'b1; wa1 = AW'(1);       wd1 = '0;
                s_d.cnt  = CW'(2);
                s_d.rptr = '0;
                s_d.wptr = '0;
                s_d.irq  = 1'b1;
                s_d.done = 1'b1;
            end
            ACT_TAKE: begin
                s_d.tlen = s_q.cnt;
                s_d.tlun = lun_fld;
                we0 = 1'b1; wa0 = '0; wd0 = {{LUN_SHIFT{1'b0}}, lun_fld};
                s_d.cnt  = '0;
                s_d.rptr = '0;
                s_d.wptr = '0;
            end
            ACT_READ: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = cnt_dec;
                    s_d.irq = 1'b1;
                    if (phase_bits == '0) begin
                        s_d.rdat = '0;
                    end else begin
                        s_d.rdat = store_rdat;
                        s_d.rptr = ptr_next(s_q.rptr);
                    end
                    if (cnt_dec == '0) begin
                        s_d.rptr = '0;
                        s_d.wptr = '0;
                    end
                end
            end
            ACT_PUSH: begin
                if (s_q.cnt == CNT_LIMIT) begin
                    s_d.ovr = 1'b1;
                end else begin
                    we0 = 1'b1; wa0 = s_q.wptr; wd0 = wr_data;
                    s_d.wptr = ptr_next(s_q.wptr);
                    s_d.cnt  = s_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ra        = s_q.rptr;
    assign count_q   = s_q.cnt;
    assign rd_data_q = s_q.rdat;
    assign irq_q     = s_q.irq;
    assign done_q    = s_q.done;
    assign ovr_q     = s_q.ovr;
    assign tlen_q    = s_q.tlen;
    assign tlun_q    = s_q.tlun;
endmodule

// File: rtl/pio_fifo_cmd.sv
module pio_fifo_cmd
    import pio_fifo_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 32,
    parameter int PH_W      = 3,
    parameter int LUN_SHIFT = 5,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int CIW      = $clog2(CMD_DEPTH),
    localparam int CLW      = $clog2(CMD_DEPTH + 1),
    localparam int LUN_W    = DATA_W - LUN_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PH_W-1:0]   phase_bits,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_pulse,
    input  logic              resp_load,
    input  logic [DATA_W-1:0] resp_status,
    output logic              resp_done,
    input  logic              cmd_take,
    output logic [CW-1:0]     take_len,
    output logic [LUN_W-1:0]  take_lun,
    input  logic [AW-1:0]     peek_idx,
    output logic [DATA_W-1:0] peek_data,
    input  logic              cmd_clear,
    input  logic [CIW-1:0]    cmd_idx,
    output logic [DATA_W-1:0] cmd_byte,
    output logic [CLW-1:0]    cmd_len,
    output logic [CW-1:0]     fifo_count,
    output logic              overrun
);
    act_e              act;
    logic              we0, we1;
    logic [AW-1:0]     wa0, wa1, ra;
    logic [DATA_W-1:0] wd0, wd1, store_rdat, lun_src;

    pio_action_arb u_arb (
        .resp_load    (resp_load),
        .cmd_take     (cmd_take),
        .rd_en        (rd_en),
        .wr_en        (wr_en),
        .capture_mode (capture_mode),
        .act          (act)
    );

    pio_byte_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LUN_IX(2)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we0     (we0),
        .wa0     (wa0),
        .wd0     (wd0),
        .we1     (we1),
        .wa1     (wa1),
        .wd1     (wd1),
        .ra      (ra),
        .rdat    (store_rdat),
        .pa      (peek_idx),
        .pdat    (peek_data),
        .lun_src (lun_src)
    );

    pio_data_ctrl #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .PH_W(PH_W), .LUN_SHIFT(LUN_SHIFT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .wr_data     (wr_data),
        .phase_bits  (phase_bits),
        .resp_status (resp_status),
        .store_rdat  (store_rdat),
        .lun_src     (lun_src),
        .we0         (we0),
        .wa0         (wa0),
        .wd0         (wd0),
        .we1         (we1),
        .wa1         (wa1),
        .wd1         (wd1),
        .ra          (ra),
        .count_q     (fifo_count),
        .rd_data_q   (rd_data),
        .irq_q       (irq_pulse),
        .done_q      (resp_done),
        .ovr_q       (overrun),
        .tlen_q      (take_len),
        .tlun_q      (take_lun)
    );

    pio_cmd_capture #(.DATA_W(DATA_W), .CMD_DEPTH(CMD_DEPTH)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .capt_en  (act == ACT_CAPT),
        .clear    (cmd_clear),
        .data     (wr_data),
        .idx      (cmd_idx),
        .byte_out (cmd_byte),
        .len_q    (cmd_len)
    );
endmodule

// File: rtl/pio_fifo_chk.sv
module pio_fifo_chk #(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 32,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int CLW      = $clog2(CMD_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_en,
    input logic           wr_en,
    input logic           capture_mode,
    input logic           resp_load,
    input logic           cmd_take,
    input logic           cmd_clear,
    input logic [7:0]     rd_data,
    input logic           irq_pulse,
    input logic           resp_done,
    input logic [CW-1:0]  take_len,
    input logic [CW-1:0]  fifo_count,
    input logic [CLW-1:0] cmd_len,
    input logic           overrun
);
    localparam logic [CW-1:0]  CNT_LIMIT = CW'(DEPTH - 1);
    localparam logic [CLW-1:0] LEN_MAX   = CLW'(CMD_DEPTH);

    assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_LIMIT);

    assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !resp_load && !cmd_take && fifo_count != '0)
        |=> (irq_pulse && (fifo_count + 1'b1 == $past(fifo_count))));

    assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !resp_load && !cmd_take && fifo_count == '0)
        |=> ($stable(rd_data) && !irq_pulse && fifo_count == '0));

    assert_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_load |=> (fifo_count == CW'(2) && irq_pulse && resp_done));

    assert_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_take && !resp_load) |=> (fifo_count == '0 && take_len == $past(fifo_count)));

    assert_cmd_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_len <= LEN_MAX);

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear |=> (cmd_len == '0));

    assert_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_load && wr_en && !capture_mode) |=> (fifo_count == CW'(2)));
endmodule

bind pio_fifo_cmd pio_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .capture_mode (capture_mode),
    .resp_load    (resp_load),
    .cmd_take     (cmd_take),
    .cmd_clear    (cmd_clear),
    .rd_data      (rd_data),
    .irq_pulse    (irq_pulse),
    .resp_done    (resp_done),
    .take_len     (take_len),
    .fifo_count   (fifo_count),
    .cmd_len      (cmd_len),
    .overrun      (overrun)
);

// File: tb/sim_pio_fifo_cmd.sv
module sim_pio_fifo_cmd;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       capture_mode = 0, wr_en = 0, rd_en = 0, resp_load = 0, cmd_take = 0, cmd_clear = 0;
    logic [7:0] wr_data = 0, resp_status = 0;
    logic [2:0] phase_bits = 0;
    logic [3:0] peek_idx = 0;
    logic [4:0] cmd_idx = 0;
    logic [7:0] rd_data, peek_data, cmd_byte;
    logic       irq_pulse, resp_done, overrun;
    logic [4:0] take_len, fifo_count;
    logic [2:0] take_lun;
    logic [5:0] cmd_len;

    int n_checks = 0;
    int n_errors = 0;

    // bench model
    logic [7:0] m_mem [16];
    logic [7:0] m_cmd [32];
    int   m_cnt, m_rp, m_wp, m_clen, m_tlen;
    logic [7:0] m_rd;
    logic [2:0] m_tlun;
    bit   m_ovr, m_irq, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_fifo_cmd u0 (
        .clk(clk), .rst_n(rst_n), .capture_mode(capture_mode), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .phase_bits(phase_bits), .rd_data(rd_data),
        .irq_pulse(irq_pulse), .resp_load(resp_load), .resp_status(resp_status),
        .resp_done(resp_done), .cmd_take(cmd_take), .take_len(take_len),
        .take_lun(take_lun), .peek_idx(peek_idx), .peek_data(peek_data),
        .cmd_clear(cmd_clear), .cmd_idx(cmd_idx), .cmd_byte(cmd_byte),
        .cmd_len(cmd_len), .fifo_count(fifo_count), .overrun(overrun)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(bit cm, bit we, bit re, bit[2:0] ph, bit rl, bit tk);
        if (rl) return (re || we || tk) ? "R10" : "R8";
        if (tk) return (re || we) ? "R10" : "R9";
        if (re) return we ? "R10" : (m_cnt == 0) ? "R6" : (ph == 0) ? "R5" : "R4";
        if (we) return cm ? "R2" : "R3";
        return "R11";
    endfunction

    task automatic model(bit cm, bit we, logic [7:0] wd, bit re, logic [2:0] ph,
                         bit rl, logic [7:0] rs, bit tk, bit cc);
        m_irq = 0; m_done = 0;
        if (cc) m_clen = 0;
        else if (!rl && !tk && !re && we && cm && m_clen < 32) begin
            m_cmd[m_clen] = wd; m_clen++;
        end
        if (rl) begin
            m_mem[0] = rs; m_mem[1] = 8'h00; m_cnt = 2; m_rp = 0; m_wp = 0;
            m_irq = 1; m_done = 1;
        end else if (tk) begin
            m_tlen = m_cnt; m_tlun = m_mem[2][7:5]; m_mem[0] = {5'b0, m_mem[2][7:5]};
            m_cnt = 0; m_rp = 0; m_wp = 0;
        end else if (re) begin
            if (m_cnt > 0) begin
                m_cnt--; m_irq = 1;
                if (ph == 0) m_rd = 0;
                else begin m_rd = m_mem[m_rp]; m_rp = (m_rp + 1) % 16; end
                if (m_cnt == 0) begin m_rp = 0; m_wp = 0; end
            end
        end else if (we && !cm) begin
            if (m_cnt == 15) m_ovr = 1;
            else begin m_mem[m_wp] = wd; m_wp = (m_wp + 1) % 16; m_cnt++; end
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "fifo_count", fifo_count, m_cnt);
        chk(tag, "rd_data", rd_data, m_rd);
        chk(tag, "irq_pulse", irq_pulse, m_irq);
        chk(tag, "resp_done", resp_done, m_done);
        chk(tag, "overrun", overrun, m_ovr);
        chk(tag, "cmd_len", cmd_len, m_clen);
        chk(tag, "take_len", take_len, m_tlen);
        chk(tag, "take_lun", take_lun, m_tlun);
    endtask

    task automatic step(bit cm, bit we, logic [7:0] wd, bit re, logic [2:0] ph,
                        bit rl, logic [7:0] rs, bit tk, bit cc);
        string tag;
        tag = tag_of(cm, we, re, ph, rl, tk);
        capture_mode = cm; wr_en = we; wr_data = wd; rd_en = re; phase_bits = ph;
        resp_load = rl; resp_status = rs; cmd_take = tk; cmd_clear = cc;
        @(posedge clk);
        model(cm, we, wd, re, ph, rl, rs, tk, cc);
        #1;
        wr_en = 0; rd_en = 0; resp_load = 0; cmd_take = 0; cmd_clear = 0;
        compare(tag);
    endtask

    task automatic peek_chk(string tag, int idx);
        peek_idx = 4'(idx);
        #1;
        chk(tag, "peek_data", peek_data, m_mem[idx]);
    endtask

    task automatic cmd_chk(int idx);
        cmd_idx = 5'(idx);
        #1;
        chk("R2", "cmd_byte", cmd_byte, m_cmd[idx]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < 16; i++) m_mem[i] = 0;
        for (int i = 0; i < 32; i++) m_cmd[i] = 0;
        m_cnt = 0; m_rp = 0; m_wp = 0; m_clen = 0; m_tlen = 0; m_rd = 0; m_tlun = 0;
        m_ovr = 0; m_irq = 0; m_done = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        compare("R1");

        // R6: empty read
        step(0, 0, 0, 1, 3'b001, 0, 0, 0, 0);
        // R3: fill to limit then overrun
        for (int i = 0; i < 15; i++) step(0, 1, 8'(8'h40 + i), 0, 0, 0, 0, 0, 0);
        step(0, 1, 8'hEE, 0, 0, 0, 0, 0, 0);
        peek_chk("R3", 14);
        // R4 and R5: reads, one with zero phase
        step(0, 0, 0, 1, 3'b111, 0, 0, 0, 0);
        step(0, 0, 0, 1, 3'b000, 0, 0, 0, 0);
        step(0, 0, 0, 1, 3'b001, 0, 0, 0, 0);
        // refill past entry 15 to wrap the write pointer
        for (int i = 0; i < 4; i++) step(0, 1, 8'(8'hA0 + i), 0, 0, 0, 0, 0, 0);
        peek_chk("R3", 0);
        // R4: drain all in order, R7 afterwards
        while (m_cnt > 0) step(0, 0, 0, 1, 3'b011, 0, 0, 0, 0);
        step(0, 1, 8'h5A, 0, 0, 0, 0, 0, 0);
        peek_chk("R7", 0);
        step(0, 0, 0, 1, 3'b011, 0, 0, 0, 0);
        // R8: response pair
        step(0, 0, 0, 0, 0, 1, 8'h02, 0, 0);
        step(0, 0, 0, 1, 3'b111, 0, 0, 0, 0);
        step(0, 0, 0, 1, 3'b111, 0, 0, 0, 0);
        // R9: take
        step(0, 1, 8'h11, 0, 0, 0, 0, 0, 0);
        step(0, 1, 8'h22, 0, 0, 0, 0, 0, 0);
        step(0, 1, 8'hA3, 0, 0, 0, 0, 0, 0);
        step(0, 1, 8'h44, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0);
        peek_chk("R9", 0);
        // R10: priority
        step(0, 1, 8'h77, 1, 3'b001, 1, 8'h81, 0, 0);
        step(0, 1, 8'h78, 1, 3'b001, 0, 0, 1, 0);
        step(0, 1, 8'h79, 0, 0, 0, 0, 0, 0);
        step(0, 1, 8'h7A, 1, 3'b001, 0, 0, 0, 0);
        // R2 and R11: capture saturation and clear
        for (int i = 0; i < 34; i++) step(1, 1, 8'(8'hC0 + i), 0, 0, 0, 0, 0, 0);
        cmd_chk(0); cmd_chk(31);
        step(1, 1, 8'h99, 0, 0, 0, 0, 0, 1);
        step(1, 1, 8'h98, 0, 0, 0, 0, 0, 0);
        cmd_chk(0);

        // random phase, write-biased
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit cm, we, re, rl, tk, cc;
            r  = int'($urandom_range(0, 99));
            cm = ($urandom_range(0, 9) == 0);
            we = (r < 55) || ($urandom_range(0, 19) == 0);
            re = (r >= 55 && r < 92) || ($urandom_range(0, 19) == 0);
            rl = (r >= 92 && r < 95);
            tk = (r >= 95 && r < 98);
            cc = (r >= 98);
            step(cm, we, 8'($urandom), re, 3'($urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 7)),
                 rl, 8'($urandom), tk, cc);
            if (n % 16 == 0) peek_chk("R7", int'($urandom_range(0, 15)));
            if (n % 64 == 0) cmd_chk(int'($urandom_range(0, 31)));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule